// File: doc/BRIEF.md
# Sequenced Two-Operand Adder Datapath

This block adds two operand words under the control of a small sequencer. It has two data registers, A and B. A multiplexer picks the value written into A, and an adder ALU combines A and B. A three-state Moore controller drives the register write enables, the multiplexer select and the ALU operation code.

When a data-valid strobe is seen in the idle state, the controller steps through a load state and then a store state. In the load state both operands are written. In the store state the sum is written back into A. Each write takes effect on the clock edge that ends the state that enables it. The result stays in register A, and register A is the block's data output. The internal control strobes and the state code are also driven to ports, so that the sequence can be observed from outside.

Top module: `add_seq_datapath`

## Requirements
- R1: A synchronous active-high reset puts the controller in idle (state code 0) and clears registers A and B to zero, overriding any pending write.
- R2: In idle (state code 0), both write enables are low. While the strobe is low the controller stays in idle and register A keeps its value, whatever the operand inputs do.
- R3: A strobe sampled high in idle moves the controller to load (state code 1) on that edge. In load, both write enables are high and the A-source select is 0, which routes the first operand input.
- R4: The operand inputs present at the clock edge that ends load are written into A and B on that edge. They are not written earlier.
- R5: In store (state code 2), the A write enable is high, the B write enable is low and the A-source select is 1, which routes the ALU result. On the edge that ends store, A receives the old A plus the old B.
- R6: The controller always moves from load to store, and from store to idle, one cycle each.
- R7: The ALU operation code is driven to 1 (add) in every state.
- R8: A strobe seen while the controller is in load or store has no effect. The sequence still returns to idle after store, and a new operation begins only from idle.
- R9: The sum wraps modulo 2^N for an N-bit data width, and the carry-out is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dv_i | input | 1 | Data-valid strobe that starts an operation |
| opnd_a_i | input | DATA_W | First operand word |
| opnd_b_i | input | DATA_W | Second operand word |
| acc_o | output | DATA_W | Contents of register A |
| sel_a_o | output | 1 | A-source select (0 = operand input, 1 = ALU result) |
| wr_a_o | output | 1 | Write enable of register A |
| wr_b_o | output | 1 | Write enable of register B |
| alu_op_o | output | 1 | ALU operation code (1 = add) |
| state_o | output | 2 | Controller state code (0 idle, 1 load, 2 store) |

## Verification
The bench builds the block with the default 8-bit data width. At this width, operand pairs such as 0xFF+0x01 and 0x80+0x80 reach the modulo wrap of the sum with only a few operations. The bench also changes the operand inputs during store and idle. This shows that only the values present at the edge that ends load are written. Strobes held high through load and store, and a reset raised in the middle of a load, exercise the ignore rule and the reset priority.

// File: rtl/addp_pkg.sv
package addp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_STORE = 2'd2
  } seq_state_e;

  localparam logic ALU_OP_ADD  = 1'b1;
  localparam logic SEL_OPERAND = 1'b0;
  localparam logic SEL_ALU     = 1'b1;

  typedef struct packed {
    logic sel_a;
    logic wr_a;
    logic wr_b;
    logic alu_op;
  } ctrl_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import addp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dv,
  output ctrl_t      ctrl,
  output seq_state_e state
);
  seq_state_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  always_comb begin
    case (st_q)
      ST_IDLE:  st_d = dv ? ST_LOAD : ST_IDLE;
      ST_LOAD:  st_d = ST_STORE;
      ST_STORE: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // Moore outputs: every field assigned in every state
  always_comb begin
    case (st_q)
      ST_LOAD: begin
        ctrl.sel_a  = SEL_OPERAND;
        ctrl.wr_a   = 1'b1;
        ctrl.wr_b   = 1'b1;
        ctrl.alu_op = ALU_OP_ADD;
      end
      ST_STORE: begin
        ctrl.sel_a  = SEL_ALU;
        ctrl.wr_a   = 1'b1;
        ctrl.wr_b   = 1'b0;
        ctrl.alu_op = ALU_OP_ADD;
      end
      default: begin
        ctrl.sel_a  = SEL_OPERAND;
        ctrl.wr_a   = 1'b0;
        ctrl.wr_b   = 1'b0;
        ctrl.alu_op = ALU_OP_ADD;
      end
    endcase
  end

  assign state = st_q;
endmodule

// File: rtl/wr_reg.sv
module wr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/a_src_mux.sv
module a_src_mux #(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] alu,
  output logic [W-1:0] y
);
  assign y = sel ? alu : opnd;
endmodule

// File: rtl/add_alu.sv
module add_alu #(
  parameter int W = 8
) (
  input  logic         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  // Sum kept to W bits; carry-out is dropped
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] x, input logic [W-1:0] z);
    logic [W:0] full;
    full = {1'b0, x} + {1'b0, z};
    return full[W-1:0];
  endfunction

  assign y = op ? wrap_add(a, b) : a;
endmodule

// File: rtl/add_seq_datapath.sv
module add_seq_datapath
  import addp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dv_i,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              sel_a_o,
  output logic              wr_a_o,
  output logic              wr_b_o,
  output logic              alu_op_o,
  output logic [1:0]        state_o
);
  localparam int NREG = 2;

  ctrl_t             ctrl;
  seq_state_e        st;
  logic [DATA_W-1:0] mux_y;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] reg_a_q;
  logic [DATA_W-1:0] reg_b_q;

  logic [DATA_W-1:0] reg_d [NREG];
  logic [DATA_W-1:0] reg_q [NREG];
  logic              reg_en[NREG];

  seq_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .dv    (dv_i),
    .ctrl  (ctrl),
    .state (st)
  );

  a_src_mux #(.W(DATA_W)) u_mux (
    .sel  (ctrl.sel_a),
    .opnd (opnd_a_i),
    .alu  (alu_y),
    .y    (mux_y)
  );

  assign reg_d[0]  = mux_y;
  assign reg_en[0] = ctrl.wr_a;
  assign reg_d[1]  = opnd_b_i;
  assign reg_en[1] = ctrl.wr_b;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    wr_reg #(.W(DATA_W)) u_reg (
      .clk (clk),
      .rst (rst),
      .en  (reg_en[g]),
      .d   (reg_d[g]),
      .q   (reg_q[g])
    );
  end

  assign reg_a_q = reg_q[0];
  assign reg_b_q = reg_q[1];

  add_alu #(.W(DATA_W)) u_alu (
    .op (ctrl.alu_op),
    .a  (reg_a_q),
    .b  (reg_b_q),
    .y  (alu_y)
  );

  assign acc_o    = reg_a_q;
  assign sel_a_o  = ctrl.sel_a;
  assign wr_a_o   = ctrl.wr_a;
  assign wr_b_o   = ctrl.wr_b;
  assign alu_op_o = ctrl.alu_op;
  assign state_o  = st;
endmodule

// File: rtl/add_seq_checks.sv
module add_seq_checks #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         dv,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic [1:0]   st,
  input logic         sel_a,
  input logic         wr_a,
  input logic         wr_b,
  input logic         alu_op
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st == 2'd0 && reg_a == '0 && reg_b == '0)); // R1
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0) |-> (!wr_a && !wr_b)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0 && !dv) |=> (st == 2'd0 && $stable(reg_a))); // R2
  AST_IDLE_TO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0 && dv) |=> (st == 2'd1)); // R3
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1) |=> (reg_a == $past(in_a) && reg_b == $past(in_b))); // R4
  AST_STORE_SUM: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd2) |=> (reg_a == W'($past(reg_a) + $past(reg_b)))); // R5
  AST_STORE_STROBES: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd2) |-> (sel_a && wr_a && !wr_b)); // R5
  AST_LOAD_TO_STORE: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1) |=> (st == 2'd2)); // R6
  AST_STORE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd2) |=> (st == 2'd0)); // R8
  AST_ALU_ADD: assert property (@(posedge clk) disable iff (rst)
    alu_op == 1'b1); // R7
endmodule

bind add_seq_datapath add_seq_checks #(.W(DATA_W)) u_checks (
  .clk    (clk),
  .rst    (rst),
  .dv     (dv_i),
  .in_a   (opnd_a_i),
  .in_b   (opnd_b_i),
  .reg_a  (reg_a_q),
  .reg_b  (reg_b_q),
  .st     (state_o),
  .sel_a  (sel_a_o),
  .wr_a   (wr_a_o),
  .wr_b   (wr_b_o),
  .alu_op (alu_op_o)
);

// File: tb/add_seq_datapath_tb.sv
`timescale 1ns/1ps
module add_seq_datapath_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dv  = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [W-1:0] acc;
  logic         sel_a, wr_a, wr_b, alu_op;
  logic [1:0]   state;

  int vecs = 0;
  int errs = 0;
  bit done = 0;
  int cyc  = 0;
  logic [W-1:0] exp_q[$];
  logic [1:0]   prev_st = 2'd0;

  always #4 clk = ~clk;

  add_seq_datapath #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .dv_i(dv), .opnd_a_i(in_a), .opnd_b_i(in_b),
    .acc_o(acc), .sel_a_o(sel_a), .wr_a_o(wr_a), .wr_b_o(wr_b),
    .alu_op_o(alu_op), .state_o(state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference sum: modulo arithmetic on integers
  function automatic logic [W-1:0] ref_sum(input int a, input int b);
    return W'((a + b) % (1 << W));
  endfunction

  // Monitor: after a store cycle, register A must hold the queued sum
  always @(negedge clk) begin
    if (!rst && prev_st == 2'd2) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected result", acc, 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(acc == e, "R5/R9 sum", acc, e);
        chk(state == 2'd0, "R6 back to idle", state, 0);
      end
    end
    prev_st = rst ? 2'd0 : state;
  end

  // Driver: one full operation, dv optionally held through load and store
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit hold_dv);
    @(negedge clk);
    dv = 1'b1; in_a = a; in_b = b;
    exp_q.push_back(ref_sum(a, b));
    @(negedge clk);
    chk(state == 2'd1, "R3 load state", state, 1);
    chk(wr_a && wr_b && !sel_a, "R3 load strobes", {sel_a, wr_a, wr_b}, 3);
    chk(alu_op == 1'b1, "R7 op in load", alu_op, 1);
    dv = hold_dv;
    @(negedge clk);
    chk(state == 2'd2, "R6 store after load", state, 2);
    chk(acc == a, "R4 A captured", acc, a);
    chk(sel_a && wr_a && !wr_b, "R5 store strobes", {sel_a, wr_a, wr_b}, 6);
    chk(alu_op == 1'b1, "R7 op in store", alu_op, 1);
    in_a = ~a; in_b = ~b;
    // the next negedge is handled by the monitor
    @(negedge clk);
    if (hold_dv) chk(state == 2'd0, "R8 dv ignored in load/store", state, 0);
    dv = 1'b0;
  endtask

  task automatic idle_hold(input int n, input logic [W-1:0] keep);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_a = W'(i * 29 + 3); in_b = W'(i * 71 + 5);
      chk(state == 2'd0, "R2 stays idle", state, 0);
      chk(!wr_a && !wr_b, "R2 no writes", {wr_a, wr_b}, 0);
      chk(acc == keep, "R2 A holds", acc, keep);
      chk(alu_op == 1'b1, "R7 op in idle", alu_op, 1);
    end
  endtask

  initial begin
    logic [W-1:0] last;
    repeat (3) @(negedge clk);
    chk(state == 2'd0 && acc == '0, "R1 reset state", {state, acc}, 0);
    chk(!wr_a && !wr_b, "R1 no writes in reset", {wr_a, wr_b}, 0);
    rst = 1'b0;
    idle_hold(3, '0);

    run_op(8'd3, 8'd4, 1'b0);
    idle_hold(2, 8'd7);
    run_op(8'hFF, 8'h01, 1'b0);                 // R9 wrap to zero
    run_op(8'h80, 8'h80, 1'b1);                 // R9 wrap, R8 held dv
    run_op(8'hA5, 8'h5A, 1'b1);                 // R8
    run_op(8'h00, 8'h00, 1'b0);
    last = 8'h00;
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] a, b;
      a = W'(k * 37 + 11); b = W'(k * 113 + 200);
      run_op(a, b, k[0]);
      last = ref_sum(a, b);
    end
    idle_hold(3, last);

    // R1: reset raised during load wins over the pending writes
    @(negedge clk);
    dv = 1'b1; in_a = 8'h55; in_b = 8'h66;
    @(negedge clk);
    chk(state == 2'd1, "R3 load before reset", state, 1);
    dv = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(state == 2'd0 && acc == '0, "R1 reset mid-op", {state, acc}, 0);
    rst = 1'b0;
    idle_hold(2, '0);
    run_op(8'h12, 8'h34, 1'b0);
    idle_hold(1, 8'h46);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 20000);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule